// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block decides which local interrupt a hart should take next. Each cycle it takes the raw pending mask, the per-source enable mask, the per-source delegation mask, the current privilege level and the machine and supervisor global enables. A source is a candidate only when it is both pending and enabled. Each candidate is then gated by the global enable of the level it targets: undelegated sources target machine level and delegated sources target supervisor level. A target level is open when the hart runs below that level, or at that level with the level's global enable set.

The lowest-numbered surviving source wins. The result is registered. The block presents a valid flag, the winning index and a full cause word that carries an interrupt marker in its top bit, so the word can be told apart from a synchronous exception code. The trap-entry logic uses these outputs to decide whether to redirect and where. The block never takes the trap itself.

Top module: `irq_sel_top`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o, idx_o and cause_o are all zero.
- R2: A source whose enable bit is clear is never selected, whatever its pending bit.
- R3: An undelegated source (delegation bit 0) survives only when privilege is below machine, or is machine (encoding 3) with m_gie_i set.
- R4: A delegated source (delegation bit 1) survives only when privilege is user (encoding 0), or is supervisor (encoding 1) with s_gie_i set.
- R5: At machine privilege, delegated sources never survive, whatever s_gie_i and m_gie_i are.
- R6: When several sources survive, idx_o is the lowest-numbered one.
- R7: When no source survives, valid_o is 0 and idx_o and cause_o are zero.
- R8: When valid_o is 1, cause_o has bit CAUSE_W-1 set, holds idx_o in its low IDX_W bits, and is zero in every other bit.
- R9: Privilege encoding 2 behaves exactly like user: both gates are open.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. One register stage sits between inputs and outputs, and the outputs hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_IRQ | Pending interrupt mask |
| en_i | input | N_IRQ | Per-source enable mask |
| deleg_i | input | N_IRQ | Per-source delegation to supervisor |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| valid_o | output | 1 | An interrupt should be taken |
| idx_o | output | IDX_W | Index of the selected source |
| cause_o | output | CAUSE_W | Cause word with the interrupt marker in its top bit |

## Verification
Every cycle, the assertions check the gating rules per level:
- disabled sources never survive;
- a closed machine or supervisor gate removes its sources;
- machine privilege blocks delegated sources;
- encoding 2 opens both gates.

They also check that the picked bit is set and has no lower survivor, that the cause word is well formed, and that the outputs lag the survivor vector by one cycle.

Only the bench scenarios can show that the whole path produces the right index for real mask combinations. These scenarios cover each privilege with each combination of global enables, random delegation splits, the two ends of the index range and the reset values. The bench also confirms that outputs do not change before the clock edge.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] en_i,
  input  logic [N_IRQ-1:0] deleg_i,
  input  priv_e            priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  output logic [N_IRQ-1:0] surv_o
);
  logic             m_open, s_open;
  logic [N_IRQ-1:0] cand;

  // encoding 2 folds onto user
  always_comb begin
    unique case (priv_i)
      PRIV_M:  begin m_open = m_gie_i; s_open = 1'b0;    end
      PRIV_S:  begin m_open = 1'b1;    s_open = s_gie_i; end
      default: begin m_open = 1'b1;    s_open = 1'b1;    end
    endcase
  end

  assign cand = pend_i & en_i;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
    assign surv_o[g] = cand[g] & (deleg_i[g] ? s_open : m_open);
  end

  a_r2_disabled_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (surv_o & ~en_i) == '0);
  a_r3_m_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_M && !m_gie_i) |-> (surv_o & ~deleg_i) == '0);
  a_r4_s_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_S && !s_gie_i) |-> (surv_o & deleg_i) == '0);
  a_r5_m_blocks_deleg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_M) |-> (surv_o & deleg_i) == '0);
  a_r9_rsv_as_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_RSV) |-> surv_o == (pend_i & en_i));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IRQ = 32,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // descending scan: last hit is the lowest set bit
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  a_r6_pick_is_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> vec_i[idx_o]);
  a_r6_pick_is_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (vec_i & ((N_IRQ'(1) << idx_o) - N_IRQ'(1))) == '0);
  a_r7_none_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_o |-> (vec_i == '0 && idx_o == '0));
endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ   = 32,
  parameter int CAUSE_W = 32,
  localparam int IDX_W  = $clog2(N_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IRQ-1:0]   pend_i,
  input  logic [N_IRQ-1:0]   en_i,
  input  logic [N_IRQ-1:0]   deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int PAD_W = CAUSE_W - 1 - IDX_W;

  logic [N_IRQ-1:0] surv;
  logic             any_c;
  logic [IDX_W-1:0] idx_c;

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_e'(priv_i)),
    .m_gie_i (m_gie_i),
    .s_gie_i (s_gie_i),
    .surv_o  (surv)
  );

  irq_pick #(.N_IRQ(N_IRQ)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (surv),
    .any_o  (any_c),
    .idx_o  (idx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      cause_o <= '0;
    end else begin
      valid_o <= any_c;
      idx_o   <= idx_c;
      cause_o <= any_c ? {1'b1, {PAD_W{1'b0}}, idx_c} : '0;
    end
  end

  a_r8_cause_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cause_o[CAUSE_W-1] && cause_o[IDX_W-1:0] == idx_o &&
                 cause_o[CAUSE_W-2:IDX_W] == '0));
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (idx_o == '0 && cause_o == '0));
  a_r10_latency_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_c |=> (valid_o && idx_o == $past(idx_c)));
  a_r10_latency_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_c |=> !valid_o);
endmodule

// File: tb/tb_irq_sel_top.sv
`timescale 1ns/1ps
module tb_irq_sel_top;
  localparam int N  = 32;
  localparam int IW = 5;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  pend = '0, en = '0, deleg = '0;
  logic [1:0]    priv = 2'd3;
  logic          mg = 1'b0, sg = 1'b0;
  logic          valid;
  logic [IW-1:0] idx;
  logic [CW-1:0] cause;

  int checks = 0;
  int fails  = 0;
  bit e_v = 1'b0;
  int e_i = 0;
  logic [CW-1:0] e_c = '0;

  always #2.5 clk = ~clk;

  irq_sel_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg),
    .valid_o(valid), .idx_o(idx), .cause_o(cause)
  );

  // behavioural reference
  task automatic model(output bit v, output int k, output logic [CW-1:0] c);
    int  p;
    bit  mo, so;
    p  = (priv == 2'd2) ? 0 : int'(priv);
    mo = (p < 3) || mg;
    so = (p == 0) || (p == 1 && sg);
    v = 0; k = 0; c = '0;
    for (int i = 0; i < N; i++) begin
      if (!v && pend[i] && en[i] && (deleg[i] ? so : mo)) begin
        v = 1; k = i;
      end
    end
    if (v) c = (CW'(1) << (CW - 1)) | CW'(k);
  endtask

  task automatic cmp(string tag);
    checks++;
    if (valid !== e_v || int'(idx) != e_i || cause !== e_c) begin
      fails++;
      $display("FAIL %s: got v=%0b idx=%0d cause=%h, exp v=%0b idx=%0d cause=%h",
               tag, valid, idx, cause, e_v, e_i, e_c);
    end
  endtask

  // drive at negedge, confirm outputs unchanged before the edge, check after
  task automatic step(input logic [N-1:0] p, input logic [N-1:0] e,
                      input logic [N-1:0] d, input logic [1:0] pr,
                      input bit m, input bit s, input string tag);
    bit nv; int ni; logic [CW-1:0] nc;
    pend = p; en = e; deleg = d; priv = pr; mg = m; sg = s;
    #1;
    cmp("R10 hold");
    model(nv, ni, nc);
    @(negedge clk);
    e_v = nv; e_i = ni; e_c = nc;
    cmp(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend = '1; en = '1; priv = 2'd0;
    repeat (3) @(negedge clk);
    cmp("R1 in reset");
    rst_ni = 1'b1;
    pend = '0; en = '0; priv = 2'd3;
    @(negedge clk);
    cmp("R1 after reset");

    step(32'h20, 32'h0, 32'h0, 2'd0, 1, 1, "R2 enable clear");
    step(32'h20, 32'hffff_ffdf, 32'h0, 2'd0, 1, 1, "R2 other enables");
    step(32'h8, 32'h8, 32'h0, 2'd3, 0, 1, "R3 M mode mgie=0");
    step(32'h8, 32'h8, 32'h0, 2'd3, 1, 0, "R3 M mode mgie=1");
    step(32'h8, 32'h8, 32'h0, 2'd1, 0, 0, "R3 S mode below M");
    step(32'h200, 32'h200, 32'h200, 2'd1, 1, 0, "R4 S mode sgie=0");
    step(32'h200, 32'h200, 32'h200, 2'd1, 0, 1, "R4 S mode sgie=1");
    step(32'h200, 32'h200, 32'h200, 2'd0, 0, 0, "R4 U mode");
    step(32'h200, 32'h200, 32'h200, 2'd3, 1, 1, "R5 M blocks delegated");
    step(32'h208, 32'hffff_ffff, 32'h8, 2'd3, 1, 1, "R5 undelegated wins");
    step(32'h8000_0001, '1, '0, 2'd0, 0, 0, "R6 bit0 vs bit31");
    step(32'h8000_0000, '1, '0, 2'd0, 0, 0, "R6 top index");
    step(32'hffff_0000, '1, '0, 2'd0, 0, 0, "R6 lowest of run");
    step(32'h0, '1, '1, 2'd0, 1, 1, "R7 nothing pending");
    step(32'h0000_0c00, '1, 32'h0000_0400, 2'd2, 0, 0, "R9 priv2 as user");
    step(32'h0000_0c00, '1, 32'h0000_0800, 2'd2, 0, 0, "R9 priv2 undelegated");
    step(32'h1f, '1, '0, 2'd3, 1, 0, "R8 cause form");

    for (int pr = 0; pr < 4; pr++)
      for (int g = 0; g < 4; g++)
        for (int r = 0; r < 60; r++)
          step($urandom, $urandom, $urandom, 2'(pr), g[0], g[1], "R3 R4 R6 R8 random");

    for (int r = 0; r < 2000; r++)
      step($urandom & $urandom, $urandom | $urandom, $urandom, 2'($urandom),
           1'($urandom), 1'($urandom), "R3 R4 R5 R7 random sparse");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule